// File: doc/BRIEF.md
# Lane Group Memory Access Coalescer

This block receives one memory request at a time from a group of sixteen lanes. Each lane supplies an active flag and a byte address, and the whole group shares one element-size code. The block decides whether a single wide transaction can serve the group. That transaction must be aligned to its own size and cover one element per lane. When it can, the block issues that one transaction, carrying the region base and the region size in bytes. When it cannot, it issues one transaction for each active lane, in turn.

Requests enter through a valid/ready pair and are accepted only while the block is idle. Transactions leave on a second valid/ready pair toward the memory side. A transaction that is stalled by a low ready is held unchanged. When the last transaction of a group has been taken, a one-cycle done pulse is raised. At the same time the block updates two outputs: one says whether the group was coalesced, and the other gives the number of transactions it took.

Top module: `hw_coalescer`

## Requirements
- R1: After reset the block is idle: req_ready is 1, mem_valid is 0, done is 0, last_coalesced is 0 and last_txn_count is 0.
- R2: A coalesced group produces exactly one transaction with mem_wide = 1. Its mem_addr is the region base and its mem_bytes is 16 times the element size. The region base is the address of element 0, so it is aligned to 16 times the element size.
- R3: If the implied region base is not a multiple of 16 times the element size, the group is not coalesced.
- R4: Every active lane k (k = 0..15) must address exactly base + k × element size. One lane that breaks this, for example two lanes swapped, makes the whole group fall back.
- R5: The addresses of lanes whose active flag is 0 have no effect on the decision or on the transactions.
- R6: req_size codes 0, 1, 2, 3 and 4 mean elements of 1, 2, 4, 8 and 16 bytes. Codes 5 to 7 are never coalesced, and their per-lane transactions carry mem_bytes = 1.
- R7: An active lane address that is not a multiple of the element size prevents coalescing.
- R8: A group that falls back produces one transaction per active lane, in ascending lane order. Each carries that lane's address, mem_bytes equal to the element size, and mem_wide = 0.
- R9: While mem_valid is 1 and mem_ready is 0, the next cycle still has mem_valid = 1, with mem_addr, mem_bytes and mem_wide unchanged.
- R10: A group with no active lane issues no transaction. done is raised in the cycle after acceptance, with last_txn_count = 0 and last_coalesced = 0.
- R11: done is a one-cycle pulse that follows the last transaction handshake. From that pulse on, last_coalesced and last_txn_count describe the finished group. req_ready stays 0 from acceptance until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A lane group request is offered |
| req_ready | output | 1 | Block is idle and accepts a group |
| req_active | input | 16 | Per-lane active flags, bit k for lane k |
| req_addr | input | 512 | Lane byte addresses, lane k in bits 32k+31..32k |
| req_size | input | 3 | Element-size code (see R6) |
| mem_valid | output | 1 | A memory transaction is offered |
| mem_ready | input | 1 | Memory side takes the transaction |
| mem_addr | output | 32 | Transaction byte address |
| mem_bytes | output | 9 | Transaction size in bytes |
| mem_wide | output | 1 | Transaction is a coalesced region access |
| done | output | 1 | One-cycle pulse when a group is finished |
| last_coalesced | output | 1 | Last finished group used one wide transaction |
| last_txn_count | output | 5 | Number of transactions the last group needed |

## Verification
The properties assume that req_active, req_addr and req_size are only meaningful in the cycle a group is accepted. They also assume that mem_ready may change freely from one cycle to the next. The stimulus keeps the request fields steady through acceptance and drops req_valid right after it. It toggles mem_ready at random so that stalls occur in the middle of a fallback sequence. Region bases are kept below the top of the address space so that the base-plus-offset arithmetic never wraps. The stimulus mixes groups that are exactly aligned with groups that have one fault each: a shifted base, swapped lanes, a sub-element offset or an unsupported size code. Inactive lanes are filled with random addresses.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WIDE = 2'd1,
    ST_LANE = 2'd2,
    ST_DONE = 2'd3
  } coal_state_t;

  localparam logic [2:0] MAX_SIZE_CODE = 3'd4;

  function automatic logic size_code_ok(input logic [2:0] code);
    return (code <= MAX_SIZE_CODE);
  endfunction

  // log2 of the element size; unsupported codes fall back to single bytes
  function automatic logic [2:0] elem_shift(input logic [2:0] code);
    return (code <= MAX_SIZE_CODE) ? code : 3'd0;
  endfunction

endpackage

// File: rtl/coal_rst_sync.sv
module coal_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/coal_lane_pick.sv
module coal_lane_pick #(
  parameter int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/coal_check.sv
module coal_check
  import coal_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 32,
  localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0]    active,
  input  logic [LANES*AW-1:0] addr,
  input  logic [2:0]          size_code,
  output logic                can_merge,
  output logic [AW-1:0]       region_base
);
  logic [2:0]          sh_elem;
  logic [5:0]          sh_region;
  logic [AW-1:0]       low_mask;
  logic [AW-1:0]       hi_part [LANES];
  logic [LANES-1:0]    lane_good;
  logic                any_act;
  logic [LW-1:0]       first_idx;
  logic [AW-1:0]       hi_first;

  assign sh_elem   = elem_shift(size_code);
  assign sh_region = {3'b000, sh_elem} + 6'(LW);
  assign low_mask  = (AW'(1) << sh_region) - AW'(1);

  coal_lane_pick #(.N(LANES)) first_i (
    .mask  (active),
    .found (any_act),
    .idx   (first_idx)
  );

  assign hi_first = hi_part[first_idx];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [AW-1:0] a_k;
    logic          low_ok;
    assign a_k        = addr[k*AW +: AW];
    assign hi_part[k] = a_k >> sh_region;
    assign low_ok     = ((a_k & low_mask) == (AW'(k) << sh_elem));
    assign lane_good[k] = !active[k] || (low_ok && (hi_part[k] == hi_first));
  end

  assign can_merge   = size_code_ok(size_code) && any_act && (&lane_good);
  assign region_base = hi_first << sh_region;
endmodule

// File: rtl/hw_coalescer.sv
module hw_coalescer
  import coal_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 32,
  localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int BW   = LW + 5,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LANES-1:0]    req_active,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [2:0]          req_size,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic [AW-1:0]       mem_addr,
  output logic [BW-1:0]       mem_bytes,
  output logic                mem_wide,
  output logic                done,
  output logic                last_coalesced,
  output logic [CW-1:0]       last_txn_count
);
  logic rst_ns;

  coal_rst_sync rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  // decision on the live request, captured at acceptance
  logic          chk_ok;
  logic [AW-1:0] chk_base;

  coal_check #(.LANES(LANES), .AW(AW)) check_i (
    .active      (req_active),
    .addr        (req_addr),
    .size_code   (req_size),
    .can_merge   (chk_ok),
    .region_base (chk_base)
  );

  coal_state_t        state_q, state_d;
  logic [LANES-1:0]   pend_q, pend_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [LANES*AW-1:0] addr_q;
  logic [2:0]         shift_q;
  logic [AW-1:0]      base_q;
  logic               res_coal_q;
  logic [CW-1:0]      res_cnt_q;

  logic               accept, hs, finish, cur_found;
  logic [LW-1:0]      cur_idx;
  logic [LANES-1:0]   cur_onehot;
  logic [4:0]         sh_region;

  coal_lane_pick #(.N(LANES)) cur_i (
    .mask  (pend_q),
    .found (cur_found),
    .idx   (cur_idx)
  );

  assign cur_onehot = LANES'(1) << cur_idx;
  assign sh_region  = {2'b00, shift_q} + 5'(LW);

  assign req_ready  = (state_q == ST_IDLE) && rst_ns;
  assign accept     = req_valid && req_ready;
  assign mem_valid  = (state_q == ST_WIDE) || ((state_q == ST_LANE) && cur_found);
  assign mem_wide   = (state_q == ST_WIDE);
  assign mem_addr   = mem_wide ? base_q : addr_q[cur_idx*AW +: AW];
  assign mem_bytes  = mem_wide ? (BW'(1) << sh_region) : (BW'(1) << shift_q);
  assign hs         = mem_valid && mem_ready;
  assign done       = (state_q == ST_DONE);
  assign last_coalesced = res_coal_q;
  assign last_txn_count = res_cnt_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    cnt_d   = cnt_q;
    finish  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          pend_d = req_active;
          cnt_d  = '0;
          if (req_active == '0) begin
            state_d = ST_DONE;
            finish  = 1'b1;
          end else if (chk_ok) begin
            state_d = ST_WIDE;
          end else begin
            state_d = ST_LANE;
          end
        end
      end
      ST_WIDE: begin
        if (hs) begin
          cnt_d   = cnt_q + CW'(1);
          state_d = ST_DONE;
          finish  = 1'b1;
        end
      end
      ST_LANE: begin
        if (hs) begin
          cnt_d  = cnt_q + CW'(1);
          pend_d = pend_q & ~cur_onehot;
          if (pend_d == '0) begin
            state_d = ST_DONE;
            finish  = 1'b1;
          end
        end else if (!cur_found) begin
          state_d = ST_DONE;
          finish  = 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      cnt_q   <= cnt_d;
    end
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      addr_q  <= '0;
      shift_q <= '0;
      base_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      shift_q <= elem_shift(req_size);
      base_q  <= chk_base;
    end
  end

  // result registers, enabled when a group finishes
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      res_coal_q <= 1'b0;
      res_cnt_q  <= '0;
    end else if (finish) begin
      res_coal_q <= (state_q == ST_WIDE);
      res_cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/hw_coalescer_chk.sv
module hw_coalescer_chk #(
  parameter int LANES = 16,
  parameter int AW    = 32,
  parameter int BW    = 9,
  parameter int CW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LANES-1:0] req_active,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic [AW-1:0]    mem_addr,
  input logic [BW-1:0]    mem_bytes,
  input logic             mem_wide,
  input logic             done,
  input logic             last_coalesced,
  input logic [CW-1:0]    last_txn_count
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_bytes) && $stable(mem_wide)));

  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid || done) |-> !req_ready);

  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_active == '0)) |=> (done && !mem_valid));

  p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_wide) |-> ((mem_addr & (AW'(mem_bytes) - AW'(1))) == '0));

  p_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && last_coalesced) |-> (last_txn_count == CW'(1)));

  p_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (last_txn_count <= CW'(LANES)));
endmodule

bind hw_coalescer hw_coalescer_chk #(
  .LANES(LANES), .AW(AW), .BW(BW), .CW(CW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_active(req_active), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_bytes(mem_bytes), .mem_wide(mem_wide),
  .done(done), .last_coalesced(last_coalesced), .last_txn_count(last_txn_count)
);

// File: tb/hw_coalescer_tb_top.sv
module hw_coalescer_tb_top;
  localparam int LANES = 16;
  localparam int AW    = 32;
  localparam int BW    = 9;
  localparam int CW    = 5;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [LANES-1:0] req_active = '0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic [2:0] req_size = '0;
  logic mem_valid;
  logic mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [BW-1:0] mem_bytes;
  logic mem_wide;
  logic done;
  logic last_coalesced;
  logic [CW-1:0] last_txn_count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int stall_pct = 50;

  logic [AW-1:0] got_addr [0:31];
  int            got_bytes[0:31];
  logic          got_wide [0:31];
  int            got_n = 0;
  logic          prev_stall = 1'b0;
  logic [AW-1:0] prev_addr;
  logic [BW-1:0] prev_bytes;

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_coalescer dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_active(req_active), .req_addr(req_addr), .req_size(req_size),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_bytes(mem_bytes), .mem_wide(mem_wide), .done(done),
    .last_coalesced(last_coalesced), .last_txn_count(last_txn_count)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      finish_run();
    end
  end

  // memory side: randomize ready at the falling edge, record the handshake due at the next rise
  always @(negedge clk) begin
    mem_ready = ($urandom % 100) >= stall_pct;
    #1;
    if (prev_stall) begin
      check(mem_valid && mem_addr == prev_addr && mem_bytes == prev_bytes,
            "R9", "stalled transaction held", longint'(mem_addr), longint'(prev_addr));
    end
    prev_stall = mem_valid && !mem_ready;
    prev_addr  = mem_addr;
    prev_bytes = mem_bytes;
    if (mem_valid && mem_ready && got_n < 32) begin
      got_addr[got_n]  = mem_addr;
      got_bytes[got_n] = int'(mem_bytes);
      got_wide[got_n]  = mem_wide;
      got_n++;
    end
  end

  task automatic run_group(input logic [LANES-1:0] act, input logic [LANES*AW-1:0] adr,
                           input logic [2:0] code, input string req);
    logic [AW-1:0] e_addr [0:15];
    int            e_bytes[0:15];
    int            e_n;
    logic          e_coal;
    int            esz;
    logic [AW-1:0] base;
    logic          have_base;
    int            wait_cyc;
    esz       = (code <= 3'd4) ? (1 << code) : 1;
    e_coal    = (code <= 3'd4) && (act != '0);
    have_base = 1'b0;
    base      = '0;
    for (int k = 0; k < LANES; k++) begin
      if (act[k]) begin
        logic [AW-1:0] cand;
        cand = adr[k*AW +: AW] - AW'(k * esz);
        if (!have_base) begin
          base = cand;
          have_base = 1'b1;
        end else if (cand != base) e_coal = 1'b0;
      end
    end
    if ((base % AW'(16 * esz)) != 0) e_coal = 1'b0;
    e_n = 0;
    if (e_coal) begin
      e_addr[0] = base; e_bytes[0] = 16 * esz; e_n = 1;
    end else begin
      for (int k = 0; k < LANES; k++)
        if (act[k]) begin
          e_addr[e_n] = adr[k*AW +: AW]; e_bytes[e_n] = esz; e_n++;
        end
    end

    @(negedge clk);
    got_n      = 0;
    req_valid  = 1'b1;
    req_active = act;
    req_addr   = adr;
    req_size   = code;
    #2;
    while (!req_ready) begin
      @(negedge clk); #2;
    end
    @(negedge clk); #2;
    req_valid = 1'b0;
    check(!req_ready, "R11", "ready low after accept", longint'(req_ready), 0);
    if (act == '0) begin
      check(done, "R10", "done one cycle after empty accept", longint'(done), 1);
    end
    wait_cyc = 0;
    while (!done && wait_cyc < 400) begin
      @(negedge clk); #2;
      wait_cyc++;
    end
    check(done, req, "group completes", longint'(done), 1);
    check(got_n == e_n, req, "transaction count", got_n, e_n);
    check(last_txn_count == CW'(e_n), "R11", "reported count", longint'(last_txn_count), e_n);
    check(last_coalesced == e_coal, req, "coalesced flag", longint'(last_coalesced), longint'(e_coal));
    for (int i = 0; i < e_n && i < got_n; i++) begin
      check(got_addr[i] == e_addr[i], e_coal ? "R2" : "R8", "txn address",
            longint'(got_addr[i]), longint'(e_addr[i]));
      check(got_bytes[i] == e_bytes[i], e_coal ? "R2" : "R8", "txn bytes",
            got_bytes[i], e_bytes[i]);
      check(got_wide[i] == e_coal, e_coal ? "R2" : "R8", "txn wide flag",
            longint'(got_wide[i]), longint'(e_coal));
    end
    @(negedge clk); #2;
    check(!done, "R11", "done is one pulse", longint'(done), 0);
  endtask

  function automatic logic [LANES*AW-1:0] lay(input logic [AW-1:0] base, input int esz);
    logic [LANES*AW-1:0] v;
    for (int k = 0; k < LANES; k++) v[k*AW +: AW] = base + AW'(k * esz);
    return v;
  endfunction

  initial begin
    logic [LANES*AW-1:0] a;
    logic [AW-1:0] t;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    check(req_ready == 1'b1, "R1", "reset req_ready", longint'(req_ready), 1);
    check(mem_valid == 1'b0, "R1", "reset mem_valid", longint'(mem_valid), 0);
    check(done == 1'b0, "R1", "reset done", longint'(done), 0);
    check(last_coalesced == 1'b0, "R1", "reset flag", longint'(last_coalesced), 0);
    check(last_txn_count == '0, "R1", "reset count", longint'(last_txn_count), 0);

    // directed corner cases
    run_group(16'hFFFF, lay(32'h0000_1000, 4), 3'd2, "R2");
    a = lay(32'h0000_2000, 4);
    a[3*AW +: AW] = 32'hDEAD_BEE1;
    a[7*AW +: AW] = 32'h0000_0013;
    run_group(16'hFF77, a, 3'd2, "R5");
    run_group(16'hFFFF, lay(32'h0000_1020, 4), 3'd2, "R3");
    a = lay(32'h0000_4000, 8);
    t = a[0 +: AW]; a[0 +: AW] = a[AW +: AW]; a[AW +: AW] = t;
    run_group(16'hFFFF, a, 3'd3, "R4");
    a = lay(32'h0000_0400, 2);
    a[9*AW +: AW] = a[9*AW +: AW] + 32'd1;
    run_group(16'hFFFF, a, 3'd1, "R7");
    for (int c = 0; c < 5; c++) run_group(16'hFFFF, lay(32'h0001_0000, 1 << c), 3'(c), "R6");
    run_group(16'hFFFF, lay(32'h0000_0800, 1), 3'd5, "R6");
    run_group(16'h0000, lay(32'h0000_0000, 4), 3'd2, "R10");
    run_group(16'h0020, lay(32'h0000_3000, 4), 3'd2, "R5");
    stall_pct = 0;
    run_group(16'hA5A5, lay(32'h0000_5010, 4), 3'd2, "R8");
    stall_pct = 50;

    // constrained random groups
    for (int n = 0; n < 300; n++) begin
      int code, esz, fault;
      logic [AW-1:0] base;
      logic [LANES-1:0] act;
      code  = (($urandom % 8) == 0) ? 5 + ($urandom % 3) : ($urandom % 5);
      esz   = (code <= 4) ? (1 << code) : 1;
      base  = ($urandom & 32'h7FFF_FFFF) & ~AW'(16 * esz - 1);
      act   = LANES'($urandom);
      if (($urandom % 6) == 0) act = '1;
      a     = lay(base, esz);
      for (int k = 0; k < LANES; k++) if (!act[k]) a[k*AW +: AW] = $urandom;
      fault = $urandom % 5;
      if (fault == 1) a = lay(base + AW'(esz * (1 + $urandom % 15)), esz);
      if (fault == 2) begin
        int i, j;
        i = $urandom % LANES; j = $urandom % LANES;
        t = a[i*AW +: AW]; a[i*AW +: AW] = a[j*AW +: AW]; a[j*AW +: AW] = t;
      end
      if (fault == 3) begin
        int i;
        i = $urandom % LANES;
        a[i*AW +: AW] = a[i*AW +: AW] + 32'd1;
      end
      run_group(act, a, 3'(code), "R8");
    end
    finish_run();
  end
endmodule